// File: doc/BRIEF.md
# Bus-Attached Multiply-Accumulate Unit

This block is a 16-bit multiplier that lives on a simple word-addressed register bus and works without any help from the processor beyond plain loads and stores. The operation type is selected by the address used to store the first operand. Four such addresses exist, one each for unsigned multiply, signed multiply, unsigned multiply-accumulate and signed multiply-accumulate. Storing the second operand launches the operation in the latched mode. The 32-bit outcome is readable in the following cycle as a low word and a high word. An extension word reports either sign or carry.

Software preloads or clears the two result words by writing them directly. It then issues a chain of accumulate operations. Writing the second operand again repeats the operation with the operand 1 already held. Reads are combinational from the address, so no wait state is ever inserted.

Top module: `mpy_periph`

## Requirements
- R1: After reset every register reads 0x0000 and the latched mode is unsigned multiply. A second-operand write issued straight after reset therefore overwrites preloaded result words and does not add to them.
- R2: A write to word address 0, 1, 2 or 3 stores operand 1 and latches the mode given by address bits [1:0]: 0 unsigned multiply, 1 signed multiply, 2 unsigned accumulate, 3 signed accumulate. The stored operand 1 reads back at all four of these addresses.
- R3: A write to address 4 stores operand 2 and starts the operation. Operand 2 reads back at address 4. The results at addresses 5 (low word), 6 (high word) and 7 (extension) are valid in the cycle after the write.
- R4: Unsigned multiply stores the unsigned 32-bit product in the result words and sets the extension to 0x0000.
- R5: Signed multiply stores the two's-complement product. The extension is 0xFFFF when the product is negative and 0x0000 otherwise.
- R6: Unsigned accumulate adds the unsigned product to the 32-bit result words, keeping the result modulo 2^32. The extension is 0x0001 on a carry out of bit 31 and 0x0000 otherwise.
- R7: Signed accumulate adds the signed product to the 32-bit result words, keeping the result modulo 2^32. The extension is 0xFFFF when bit 31 of the new result is set and 0x0000 otherwise.
- R8: Writing operand 2 again repeats the operation, using the stored operand 1 and the latched mode.
- R9: The low and high result words are writable at addresses 5 and 6. The extension word is read-only: a write to address 7 changes nothing. Operand-1 writes leave the result and extension words unchanged.
- R10: Addresses 8 to 15 read as 0x0000, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 4 | Word address of the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |

## Verification
The in-RTL assertions check the following on every cycle:
- the extension word moves only on a second-operand write;
- operand 1 moves only on its own writes;
- the result words hold when no write targets them;
- the extension value matches the mode and the new high word after each operation.

The arithmetic itself, meaning exact products and sums for signed and unsigned corner operands across all four modes, is shown only by the bench's sweep. The bench also covers accumulation chains with carry, repeated launches, read-only and unmapped addresses, and the reset-default mode.

// File: rtl/mpy_pkg.sv
package mpy_pkg;

  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } mpy_mode_e;

  typedef enum logic [2:0] {
    SEL_OP1  = 3'd0,
    SEL_OP2  = 3'd1,
    SEL_RLO  = 3'd2,
    SEL_RHI  = 3'd3,
    SEL_EXT  = 3'd4,
    SEL_NONE = 3'd5
  } rd_sel_e;

  // word indices within the block (op1 indices 0..3 encode the mode)
  localparam int unsigned IDX_OP2 = 4;
  localparam int unsigned IDX_RLO = 5;
  localparam int unsigned IDX_RHI = 6;
  localparam int unsigned IDX_EXT = 7;
  localparam int unsigned IDX_SPAN = 8;

endpackage

// File: rtl/mpy_rst_sync.sv
module mpy_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/mpy_decode.sv
module mpy_decode
  import mpy_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              op1_we,
  output logic              op2_we,
  output logic              rlo_we,
  output logic              rhi_we,
  output mpy_mode_e         mode_sel,
  output rd_sel_e           rd_sel
);
  localparam int unsigned IW = $clog2(IDX_SPAN);

  logic          in_range;
  logic [IW-1:0] idx;

  always_comb begin
    in_range = (addr >> IW) == '0;
    idx      = addr[IW-1:0];
    mode_sel = mpy_mode_e'(idx[1:0]);
    op1_we   = 1'b0;
    op2_we   = 1'b0;
    rlo_we   = 1'b0;
    rhi_we   = 1'b0;
    rd_sel   = SEL_NONE;
    if (in_range) begin
      if (idx < IW'(IDX_OP2)) begin
        rd_sel = SEL_OP1;
        op1_we = wr_en;
      end else if (idx == IW'(IDX_OP2)) begin
        rd_sel = SEL_OP2;
        op2_we = wr_en;
      end else if (idx == IW'(IDX_RLO)) begin
        rd_sel = SEL_RLO;
        rlo_we = wr_en;
      end else if (idx == IW'(IDX_RHI)) begin
        rd_sel = SEL_RHI;
        rhi_we = wr_en;
      end else begin
        rd_sel = SEL_EXT;
      end
    end
  end
endmodule

// File: rtl/mpy_core.sv
module mpy_core
  import mpy_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  mpy_mode_e         mode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic [DATA_W-1:0] ext
);
  localparam int unsigned PW = 2 * DATA_W;

  logic signed [PW-1:0] sa, sb;
  logic        [PW-1:0] uprod, sprod, prod, acc, res;
  logic        [PW:0]   sum;
  logic                 is_signed;

  always_comb begin
    is_signed = (mode == MODE_SMUL) || (mode == MODE_SMAC);
    sa        = PW'($signed(opa));
    sb        = PW'($signed(opb));
    uprod     = PW'(opa) * PW'(opb);
    sprod     = sa * sb;
    prod      = is_signed ? sprod : uprod;
    acc       = {acc_hi, acc_lo};
    sum       = {1'b0, acc} + {1'b0, prod};
    case (mode)
      MODE_UMUL: begin
        res = prod;
        ext = '0;
      end
      MODE_SMUL: begin
        res = prod;
        ext = {DATA_W{prod[PW-1]}};
      end
      MODE_UMAC: begin
        res = sum[PW-1:0];
        ext = {{(DATA_W-1){1'b0}}, sum[PW]};
      end
      default: begin
        res = sum[PW-1:0];
        ext = {DATA_W{sum[PW-1]}};
      end
    endcase
    res_lo = res[DATA_W-1:0];
    res_hi = res[PW-1:DATA_W];
  end
endmodule

// File: rtl/mpy_periph.sv
module mpy_periph
  import mpy_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic rst_q_n;
  logic op1_we, op2_we, rlo_we, rhi_we;
  mpy_mode_e mode_sel, mode_q;
  rd_sel_e   rd_sel;

  logic [DATA_W-1:0] op1_q, op2_q, rlo_q, rhi_q, ext_q;
  logic [DATA_W-1:0] rlo_d, rhi_d;
  logic              rlo_en, rhi_en;
  logic [DATA_W-1:0] core_lo, core_hi, core_ext;

  mpy_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  mpy_decode #(.ADDR_W(ADDR_W)) i_decode (
    .wr_en    (wr_en),
    .addr     (addr),
    .op1_we   (op1_we),
    .op2_we   (op2_we),
    .rlo_we   (rlo_we),
    .rhi_we   (rhi_we),
    .mode_sel (mode_sel),
    .rd_sel   (rd_sel)
  );

  // operand 2 feeds the core straight from the bus so the result lands one edge later
  mpy_core #(.DATA_W(DATA_W)) i_core (
    .mode   (mode_q),
    .opa    (op1_q),
    .opb    (wr_data),
    .acc_lo (rlo_q),
    .acc_hi (rhi_q),
    .res_lo (core_lo),
    .res_hi (core_hi),
    .ext    (core_ext)
  );

  // next-state selection for the result words
  always_comb begin
    rlo_en = op2_we | rlo_we;
    rhi_en = op2_we | rhi_we;
    rlo_d  = op2_we ? core_lo : wr_data;
    rhi_d  = op2_we ? core_hi : wr_data;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      op1_q  <= '0;
      op2_q  <= '0;
      rlo_q  <= '0;
      rhi_q  <= '0;
      ext_q  <= '0;
      mode_q <= MODE_UMUL;
    end else begin
      if (op1_we) begin
        op1_q  <= wr_data;
        mode_q <= mode_sel;
      end
      if (op2_we) begin
        op2_q <= wr_data;
        ext_q <= core_ext;
      end
      if (rlo_en) rlo_q <= rlo_d;
      if (rhi_en) rhi_q <= rhi_d;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_OP1: rd_data = op1_q;
      SEL_OP2: rd_data = op2_q;
      SEL_RLO: rd_data = rlo_q;
      SEL_RHI: rd_data = rhi_q;
      SEL_EXT: rd_data = ext_q;
      default: rd_data = '0;
    endcase
  end

  // R9: extension word only moves on an operand-2 write
  a_r9_ext_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !op2_we |=> $stable(ext_q));

  // R2: operand 1 only moves on its own writes
  a_r2_op1_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !op1_we |=> ($stable(op1_q) && $stable(mode_q)));

  // R3: result words hold when nothing targets them
  a_r3_res_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(op2_we || rlo_we || rhi_we) |=> ($stable(rlo_q) && $stable(rhi_q)));

  // R4: unsigned multiply leaves a zero extension
  a_r4_umul_ext: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op2_we && mode_q == MODE_UMUL) |=> (ext_q == '0));

  // R5: signed multiply extension mirrors the sign of the new high word
  a_r5_smul_ext: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op2_we && mode_q == MODE_SMUL) |=> (ext_q == {DATA_W{rhi_q[DATA_W-1]}}));

  // R6: unsigned accumulate extension is a single carry bit
  a_r6_umac_ext: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op2_we && mode_q == MODE_UMAC) |=> (ext_q[DATA_W-1:1] == '0));

  // R7: signed accumulate extension mirrors the sign of the new high word
  a_r7_smac_ext: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op2_we && mode_q == MODE_SMAC) |=> (ext_q == {DATA_W{rhi_q[DATA_W-1]}}));

endmodule

// File: tb/test_mpy_periph.sv
module test_mpy_periph;
  localparam int W  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                            16'h8000, 16'hFFFF, 16'h1234, 16'hC3A5};
  string tags [4] = '{"R4", "R5", "R6", "R7"};

  logic [31:0] macc;
  logic [15:0] mext;
  logic [15:0] mop1, mop2;

  always #2 clk = ~clk;

  mpy_periph #(.DATA_W(W), .ADDR_W(AW)) i_mpy_periph (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    addr = AW'(a);
    #0.5;
    d = rd_data;
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic rchk(input string tag, input string what, input int a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, what, v, exp);
  endtask

  // bench model: applies mode m with mop1 and b to macc
  task automatic model(input int m, input logic [15:0] b);
    logic [31:0] p;
    logic [32:0] s;
    longint sa, sb;
    sa = longint'($signed(mop1));
    sb = longint'($signed(b));
    if (m % 2 == 1) p = 32'(sa * sb);
    else            p = 32'(mop1) * 32'(b);
    s = {1'b0, macc} + {1'b0, p};
    case (m)
      0: begin macc = p; mext = 16'h0000; end
      1: begin macc = p; mext = p[31] ? 16'hFFFF : 16'h0000; end
      2: begin macc = s[31:0]; mext = {15'h0, s[32]}; end
      default: begin macc = s[31:0]; mext = s[31] ? 16'hFFFF : 16'h0000; end
    endcase
    mop2 = b;
  endtask

  task automatic check_results(input string tag);
    rchk(tag, "result low", 5, macc[15:0]);
    rchk(tag, "result high", 6, macc[31:16]);
    rchk(tag, "extension", 7, mext);
  endtask

  task automatic launch(input int m, input logic [15:0] b);
    wr(4, b);
    model(m, b);
  endtask

  task automatic preload(input logic [31:0] v);
    wr(5, v[15:0]);
    wr(6, v[31:16]);
    macc = v;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    macc = '0; mext = '0; mop1 = '0; mop2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: everything reads zero after reset
    for (int a = 0; a < 8; a++) rchk("R1", "reset value", a, 16'h0000);

    // R1: default mode is unsigned multiply (overwrites preload)
    preload(32'h0007_0009);
    launch(0, 16'h0003);
    check_results("R1");

    // R2: op1 via accumulate address reads back at all four op1 addresses
    wr(2, 16'hBEEF);
    mop1 = 16'hBEEF;
    for (int a = 0; a < 4; a++) rchk("R2", "op1 readback", a, 16'hBEEF);

    // main sweep over all modes and corner operand pairs
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          wr(m, vals[i]);
          mop1 = vals[i];
          if (m >= 2) preload({vals[(i + j + 1) % 8], vals[(3 * i + j) % 8]});
          launch(m, vals[j]);
          check_results(tags[m]);
          rchk("R3", "op2 readback", 4, vals[j]);
        end
      end
    end

    // R8: repeated operand-2 writes accumulate with stored operand 1 (unsigned, with carry)
    wr(2, 16'hFFFF);
    mop1 = 16'hFFFF;
    preload(32'h0);
    for (int k = 0; k < 4; k++) begin
      launch(2, 16'hFFFF);
      check_results("R8");
    end

    // R8: signed chain crosses zero
    wr(3, 16'hFFFF);
    mop1 = 16'hFFFF;
    preload(32'h0000_0002);
    for (int k = 0; k < 4; k++) begin
      launch(3, 16'h0001);
      check_results("R8");
    end

    // R9: direct writes to result words; extension read-only; op1 writes leave results
    preload(32'hA5A5_5A5A);
    rchk("R9", "written low", 5, 16'h5A5A);
    rchk("R9", "written high", 6, 16'hA5A5);
    wr(7, 16'h1357);
    rchk("R9", "extension after write", 7, mext);
    wr(1, 16'h4444);
    mop1 = 16'h4444;
    check_results("R9");

    // R10: unmapped addresses read zero and writes change nothing
    for (int a = 8; a < 16; a++) begin
      wr(a, 16'hAAAA);
      rchk("R10", "unmapped read", a, 16'h0000);
    end
    for (int a = 0; a < 4; a++) rchk("R10", "op1 untouched", a, mop1);
    rchk("R10", "op2 untouched", 4, mop2);
    check_results("R10");

    // R2: latched mode follows the last op1 address (signed multiply from index 1)
    launch(1, 16'hFFFE);
    check_results("R2");
    rd(4, v);
    chk("R3", "op2 after launch", v, 16'hFFFE);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule